// File: doc/BRIEF.md
# D-Channel Access Priority Arbiter

This block decides, for one terminal on a shared point-to-multipoint subscriber bus, when it may start sending a frame on the common signalling (D) channel. It watches the echo bit that the network side sends back for every D-channel bit slot and counts how many ones in a row it has seen. When the run of ones reaches a terminal count and the local HDLC transmitter has a frame waiting, the terminal gets the channel. The transmitter then starts with its opening flag.

The terminal count depends on two things. The first is a user-selected priority class: high uses a base of 8 and low uses a base of 10. The second is an internal fairness level, which adds one to the base when it is low. After each frame that finishes without a collision, the internal level drops. It rises again only once the terminal has seen the longer run of ones one time. While the terminal sends, every echoed bit is compared with the bit that was driven. A mismatch means that another terminal won the bus. The block then drops the grant at once, tells the transmitter to discard the rest of the packet, raises a sticky collision interrupt, withdraws its acknowledge flag at the next frame pulse, and starts counting again from zero.

Top module: `dch_access_arb`

## Requirements
- R1: A cycle with `echo_vld`=1 and `echo_bit`=1 adds one to the run count. A cycle with `echo_vld`=1 and `echo_bit`=0 sets the run count to zero. A cycle with `echo_vld`=0 leaves the run count unchanged, whatever `echo_bit` holds.
- R2: The terminal count is 8 for `pri_low`=0 and 10 for `pri_low`=1 while the internal level is high. It is 9 and 11 respectively while the internal level is low.
- R3: While `grant`=0 and `tx_req`=1, the strobe that brings the run count to the terminal count makes `grant` go to 1 on the same clock edge.
- R4: Without a transmit request, the run count stops at the terminal count. If `tx_req` then rises while the count is at terminal, `grant` is 1 one cycle later, even with no echo strobe.
- R5: A `tx_eof` while `grant`=1 with no collision in that cycle drops `grant` and sets the internal level low. The next grant then needs 9 ones (high class) or 11 ones (low class).
- R6: While the internal level is low and no frame is being sent, a run count that reaches the low-level terminal count sets the internal level back to high, with or without a pending request.
- R7: While `grant`=1, a strobe with `echo_bit` different from `tx_dbit` is a collision. On the next edge `grant` goes to 0 and `abort_pkt` pulses for exactly one cycle. Counting restarts from zero, and the internal level is left unchanged.
- R8: `coll_irq` goes to 1 on a collision and stays at 1 until a cycle with `stat_rd`=1. A collision in the same cycle as `stat_rd` wins.
- R9: `dc_ack` goes to 1 with `grant` and falls to 0 on a successful `tx_eof`. After a collision it falls on the first `frame_pulse` cycle that follows.
- R10: While `rst` is high, and after it, all outputs are 0 and the internal level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| echo_bit | input | 1 | Echoed D-channel bit from the network side |
| echo_vld | input | 1 | Strobe: `echo_bit` is valid for this bit slot |
| tx_dbit | input | 1 | D bit this terminal drives in the current slot |
| pri_low | input | 1 | User priority class: 0 high, 1 low |
| tx_req | input | 1 | HDLC transmitter has a frame waiting |
| tx_eof | input | 1 | HDLC transmitter finished the frame (closing flag sent) |
| frame_pulse | input | 1 | Frame boundary pulse |
| stat_rd | input | 1 | Status read strobe, clears `coll_irq` |
| grant | output | 1 | Channel granted: send opening flag and frame |
| coll_irq | output | 1 | Sticky collision interrupt |
| dc_ack | output | 1 | D-channel access acknowledge |
| abort_pkt | output | 1 | One-cycle pulse: discard the rest of the packet |

## Verification
Every output is a register that is updated on the clock edge sampling the stimulus that causes it. A grant, abort, interrupt or acknowledge change is therefore visible one cycle after the input is presented, with no extra pipeline. The bench drives inputs just after a rising edge and compares all four outputs 1 ns after the next rising edge. It uses directed sequences that count ones to the exact terminal count, and a cycle-level reference model for random traffic. The reference model advances on the same edge as the design.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic {
    TX_WAIT = 1'b0,
    TX_SEND = 1'b1
  } tx_st_e;
endpackage

// File: rtl/dch_pri_level.sv
module dch_pri_level #(
  parameter int BASE_HI = 8,
  parameter int BASE_LO = 10,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pri_low,
  input  logic             lvl_drop,
  input  logic             lvl_raise,
  output logic             lvl_hi,
  output logic [CNT_W-1:0] term
);
  localparam logic [CNT_W-1:0] T_HI = CNT_W'(BASE_HI);
  localparam logic [CNT_W-1:0] T_LO = CNT_W'(BASE_LO);

  always_ff @(posedge clk) begin
    if (rst)            lvl_hi <= 1'b1;
    else if (lvl_drop)  lvl_hi <= 1'b0;
    else if (lvl_raise) lvl_hi <= 1'b1;
  end

  always_comb begin
    term = pri_low ? T_LO : T_HI;
    if (!lvl_hi) term = term + CNT_W'(1);
  end
endmodule

// File: rtl/dch_echo_cnt.sv
module dch_echo_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             echo_vld,
  input  logic             echo_bit,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic             reach
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nxt;

  always_comb begin
    run_nxt = run_q;
    if (echo_vld) begin
      if (!echo_bit)          run_nxt = '0;
      else if (run_q < term)  run_nxt = run_q + CNT_W'(1);
    end
  end

  assign reach = (run_nxt >= term);

  always_ff @(posedge clk) begin
    if (rst || clr) run_q <= '0;
    else            run_q <= run_nxt;
  end
endmodule

// File: rtl/dch_tx_ctl.sv
module dch_tx_ctl
  import dch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reach,
  input  logic lvl_hi,
  input  logic echo_vld,
  input  logic echo_bit,
  input  logic tx_dbit,
  input  logic tx_req,
  input  logic tx_eof,
  input  logic frame_pulse,
  input  logic stat_rd,
  output logic cnt_clr,
  output logic lvl_drop,
  output logic lvl_raise,
  output logic grant,
  output logic coll_irq,
  output logic dc_ack,
  output logic abort_pkt
);
  tx_st_e st_q;
  logic   ack_pend_q;
  logic   go, coll, done;

  assign go        = (st_q == TX_WAIT) && tx_req && reach;
  assign coll      = (st_q == TX_SEND) && echo_vld && (echo_bit != tx_dbit);
  assign done      = (st_q == TX_SEND) && tx_eof && !coll;
  assign cnt_clr   = (st_q == TX_SEND) || go;
  assign lvl_drop  = done;
  assign lvl_raise = (st_q == TX_WAIT) && !lvl_hi && reach;
  assign grant     = (st_q == TX_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= TX_WAIT;
      abort_pkt  <= 1'b0;
      coll_irq   <= 1'b0;
      dc_ack     <= 1'b0;
      ack_pend_q <= 1'b0;
    end else begin
      abort_pkt <= coll;
      if (go)               st_q <= TX_SEND;
      else if (coll || done) st_q <= TX_WAIT;

      if (coll)         coll_irq <= 1'b1;
      else if (stat_rd) coll_irq <= 1'b0;

      if (go) begin
        dc_ack     <= 1'b1;
        ack_pend_q <= 1'b0;
      end else if (done) begin
        dc_ack     <= 1'b0;
      end else if (coll) begin
        ack_pend_q <= 1'b1;
      end else if (ack_pend_q && frame_pulse) begin
        dc_ack     <= 1'b0;
        ack_pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dch_access_arb.sv
module dch_access_arb #(
  parameter int BASE_HI = 8,
  parameter int BASE_LO = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic echo_bit,
  input  logic echo_vld,
  input  logic tx_dbit,
  input  logic pri_low,
  input  logic tx_req,
  input  logic tx_eof,
  input  logic frame_pulse,
  input  logic stat_rd,
  output logic grant,
  output logic coll_irq,
  output logic dc_ack,
  output logic abort_pkt
);
  localparam int MAX_T = (BASE_LO > BASE_HI ? BASE_LO : BASE_HI) + 1;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] term;
  logic lvl_hi, reach, cnt_clr, lvl_drop, lvl_raise;

  dch_pri_level #(.BASE_HI(BASE_HI), .BASE_LO(BASE_LO), .CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst(rst), .pri_low(pri_low), .lvl_drop(lvl_drop),
    .lvl_raise(lvl_raise), .lvl_hi(lvl_hi), .term(term)
  );

  dch_echo_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .echo_vld(echo_vld), .echo_bit(echo_bit),
    .clr(cnt_clr), .term(term), .reach(reach)
  );

  dch_tx_ctl u_ctl (
    .clk(clk), .rst(rst), .reach(reach), .lvl_hi(lvl_hi),
    .echo_vld(echo_vld), .echo_bit(echo_bit), .tx_dbit(tx_dbit),
    .tx_req(tx_req), .tx_eof(tx_eof), .frame_pulse(frame_pulse),
    .stat_rd(stat_rd), .cnt_clr(cnt_clr), .lvl_drop(lvl_drop),
    .lvl_raise(lvl_raise), .grant(grant), .coll_irq(coll_irq),
    .dc_ack(dc_ack), .abort_pkt(abort_pkt)
  );
endmodule

// File: rtl/dch_access_arb_chk.sv
module dch_access_arb_chk (
  input logic clk,
  input logic rst,
  input logic echo_bit,
  input logic echo_vld,
  input logic tx_dbit,
  input logic tx_req,
  input logic tx_eof,
  input logic stat_rd,
  input logic grant,
  input logic coll_irq,
  input logic dc_ack,
  input logic abort_pkt
);
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(tx_req)); // R3
  AST_ACK_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> dc_ack); // R9
  AST_COLL_DROPS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (grant && echo_vld && (echo_bit != tx_dbit)) |=> (!grant && abort_pkt)); // R7
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    abort_pkt |=> !abort_pkt); // R7
  AST_IRQ_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
    abort_pkt |-> coll_irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (coll_irq && !stat_rd) |=> coll_irq); // R8
  AST_EOF_ENDS_SEND: assert property (@(posedge clk) disable iff (rst)
    (grant && tx_eof && !(echo_vld && (echo_bit != tx_dbit))) |=> (!grant && !dc_ack)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !(grant || coll_irq || dc_ack || abort_pkt)); // R10
endmodule

bind dch_access_arb dch_access_arb_chk u_chk (
  .clk(clk), .rst(rst), .echo_bit(echo_bit), .echo_vld(echo_vld),
  .tx_dbit(tx_dbit), .tx_req(tx_req), .tx_eof(tx_eof), .stat_rd(stat_rd),
  .grant(grant), .coll_irq(coll_irq), .dc_ack(dc_ack), .abort_pkt(abort_pkt)
);

// File: tb/dch_access_arb_tb.sv
module dch_access_arb_tb;
  localparam int CLK_NS = 10;
  localparam int B_HI = 8;
  localparam int B_LO = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic echo_bit = 1'b0, echo_vld = 1'b0, tx_dbit = 1'b1, pri_low = 1'b0;
  logic tx_req = 1'b0, tx_eof = 1'b0, frame_pulse = 1'b0, stat_rd = 1'b0;
  logic grant, coll_irq, dc_ack, abort_pkt;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // reference model state
  int  m_cnt;
  bit  m_lvl, m_send, m_irq, m_ack, m_pend, m_abort;

  always #(CLK_NS/2) clk = ~clk;

  dch_access_arb #(.BASE_HI(B_HI), .BASE_LO(B_LO)) u_dut (
    .clk(clk), .rst(rst), .echo_bit(echo_bit), .echo_vld(echo_vld),
    .tx_dbit(tx_dbit), .pri_low(pri_low), .tx_req(tx_req), .tx_eof(tx_eof),
    .frame_pulse(frame_pulse), .stat_rd(stat_rd), .grant(grant),
    .coll_irq(coll_irq), .dc_ack(dc_ack), .abort_pkt(abort_pkt)
  );

  function automatic int term_of(bit low_cls, bit lvl_hi);
    return (low_cls ? B_LO : B_HI) + (lvl_hi ? 0 : 1);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_lvl = 1; m_send = 0; m_irq = 0; m_ack = 0; m_pend = 0; m_abort = 0;
  endtask

  task automatic model_step();
    int t, nxt;
    bit reach, coll, fin, go;
    t   = term_of(pri_low, m_lvl);
    nxt = m_cnt;
    if (echo_vld) nxt = echo_bit ? ((m_cnt >= t) ? m_cnt : m_cnt + 1) : 0;
    reach = (nxt >= t);
    coll  = m_send && echo_vld && (echo_bit != tx_dbit);
    fin   = m_send && tx_eof && !coll;
    go    = !m_send && tx_req && reach;
    m_abort = coll;
    if (coll) m_irq = 1; else if (stat_rd) m_irq = 0;
    if (go) begin m_ack = 1; m_pend = 0; end
    else if (fin) m_ack = 0;
    else if (coll) m_pend = 1;
    else if (m_pend && frame_pulse) begin m_ack = 0; m_pend = 0; end
    if (fin) m_lvl = 0;
    else if (!m_send && !m_lvl && reach) m_lvl = 1;
    m_cnt = (m_send || go) ? 0 : nxt;
    if (go) m_send = 1; else if (coll || fin) m_send = 0;
  endtask

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: inputs already set; after edge, sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    echo_vld = 0; echo_bit = 0; tx_eof = 0; frame_pulse = 0; stat_rd = 0;
  endtask

  task automatic one_echo(bit b);
    idle_in(); echo_vld = 1; echo_bit = b; tick(); idle_in();
  endtask

  // feed ones; grant must stay low for n-1 strobes and rise on the nth
  task automatic ones_to_grant(int n, string tag);
    for (int i = 1; i < n; i++) begin
      one_echo(1);
      chk(tag, "grant before terminal count", grant, 1'b0);
    end
    one_echo(1);
    chk(tag, "grant at terminal count", grant, 1'b1);
  endtask

  task automatic finish_ok(string tag);
    idle_in(); tx_eof = 1; tx_req = 0; tick(); idle_in();
    chk(tag, "grant after eof", grant, 1'b0);
    chk("R9", "dc_ack after eof", dc_ack, 1'b0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d1c));
    #1;
    tick(); tick(); tick();
    // R10 reset state
    chk("R10", "grant in reset", grant, 1'b0);
    chk("R10", "coll_irq in reset", coll_irq, 1'b0);
    chk("R10", "dc_ack in reset", dc_ack, 1'b0);
    chk("R10", "abort in reset", abort_pkt, 1'b0);
    rst = 0;
    tick();
    chk("R10", "grant after reset", grant, 1'b0);

    // R1: strobe-less zeros do not reset the run; R2/R3 high class count 8
    tx_req = 1;
    for (int i = 0; i < 4; i++) one_echo(1);
    idle_in(); echo_vld = 0; echo_bit = 0; tick(); tick();
    for (int i = 0; i < 3; i++) one_echo(1);
    chk("R1", "no grant after 7 ones", grant, 1'b0);
    one_echo(1);
    chk("R1", "grant on 8th one across idle gap", grant, 1'b1);
    chk("R9", "dc_ack with grant", dc_ack, 1'b1);
    finish_ok("R5");

    // R1: strobed zero resets; R5 level low so 9 needed
    tx_req = 1;
    for (int i = 0; i < 5; i++) one_echo(1);
    one_echo(0);
    ones_to_grant(9, "R5");
    // collision while sending (level was restored at 9)
    idle_in(); tx_dbit = 1; echo_vld = 1; echo_bit = 0; tick(); idle_in();
    chk("R7", "grant dropped on collision", grant, 1'b0);
    chk("R7", "abort pulse", abort_pkt, 1'b1);
    chk("R8", "irq on collision", coll_irq, 1'b1);
    chk("R9", "ack held until frame pulse", dc_ack, 1'b1);
    tick();
    chk("R7", "abort one cycle", abort_pkt, 1'b0);
    chk("R8", "irq sticky", coll_irq, 1'b1);
    frame_pulse = 1; tick(); idle_in();
    chk("R9", "ack cleared at frame pulse", dc_ack, 1'b0);
    stat_rd = 1; tick(); idle_in();
    chk("R8", "irq cleared by read", coll_irq, 1'b0);
    // R7: restart from zero, level unchanged (high) -> 8
    ones_to_grant(8, "R7");
    finish_ok("R5");

    // R6: level low; 12 ones without request restores level, zero, then 8
    for (int i = 0; i < 12; i++) one_echo(1);
    chk("R4", "no grant without request", grant, 1'b0);
    one_echo(0);
    tx_req = 1;
    ones_to_grant(8, "R6");
    finish_ok("R6");

    // R2 low class, level low -> 11
    pri_low = 1; tx_req = 1;
    ones_to_grant(11, "R2");
    finish_ok("R2");
    // R4 saturation then late request; level restored at 11 -> term 10
    tx_req = 0;
    for (int i = 0; i < 14; i++) one_echo(1);
    idle_in(); tx_req = 1; tick();
    chk("R4", "grant one cycle after late request", grant, 1'b1);
    finish_ok("R4");
    // R2 low class level high needs 10: after R4 send level low -> restore first
    for (int i = 0; i < 11; i++) one_echo(1);
    one_echo(0);
    tx_req = 1;
    ones_to_grant(10, "R2");
    finish_ok("R2");

    // R8 collision and read in same cycle: set wins
    pri_low = 0; tx_req = 1;
    ones_to_grant(9, "R5");
    idle_in(); tx_dbit = 0; echo_vld = 1; echo_bit = 1; stat_rd = 1; tick(); idle_in();
    chk("R8", "set wins over read", coll_irq, 1'b1);
    stat_rd = 1; tick(); idle_in();

    // random phase against model
    rst = 1; idle_in(); tx_req = 0; tick(); tick();
    rst = 0; model_reset();
    for (int c = 0; c < 6000; c++) begin
      tx_dbit  = 1'($urandom_range(0, 1));
      echo_vld = ($urandom_range(0, 3) != 0);
      if (m_send) echo_bit = ($urandom_range(0, 29) == 0) ? ~tx_dbit : tx_dbit;
      else        echo_bit = ($urandom_range(0, 11) != 0);
      tx_eof      = m_send && ($urandom_range(0, 15) == 0);
      frame_pulse = ($urandom_range(0, 7) == 0);
      stat_rd     = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) tx_req = ~tx_req;
      if ($urandom_range(0, 199) == 0) pri_low = ~pri_low;
      @(posedge clk);
      model_step();
      #1;
      chk("R3", "random grant", grant, m_send);
      chk("R7", "random abort", abort_pkt, m_abort);
      chk("R8", "random irq", coll_irq, m_irq);
      chk("R9", "random ack", dc_ack, m_ack);
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule